// File: doc/BRIEF.md
# Flux Transition Timestamp Capture

This block watches the raw read-data line of a disk drive and records when that line changes level. The line is asynchronous to the chip. It is sampled by a fast, free-running clock, put through a short synchronizer, and compared with its value one cycle earlier. When the selected kind of change is seen, the block captures the current value of a free-running time counter. The stream of captured values is a raw record of flux timing. A consumer can store it and later decode the disk format from the intervals between values.

Two detect modes are available. In the first, every change of the line is recorded. In the second, only changes in one direction are recorded; a parameter chooses that direction. Timestamps leave through a valid/ready stream that is meant to feed a FIFO. A two-entry holding stage (the output register plus one skid entry) absorbs short stalls. If a third change arrives while both entries are full and the stream is stalled, that timestamp is dropped and a sticky flag is raised. The counter wraps freely. Interval arithmetic is left to the consumer. No logic runs on the data line's own edges.

Top module: `flux_stamp`

## Requirements
- R1: While `rst_n` is low, and after it rises, `ts_valid` and `ovf` stay 0 until a qualifying change of `rd_line` is captured. The internal synchronizer holds a line level of 0 during reset.
- R2: Edges are numbered 1, 2, 3, ... starting with the first rising clock edge after `rst_n` rises. A change of `rd_line` that is first sampled at edge E produces a timestamp equal to E modulo 2^TS_W. That timestamp is presented on `ts_data`, with `ts_valid` high, right after edge E+3.
- R3: When `any_edge` is 1, every change of `rd_line` (0 to 1 and 1 to 0) produces exactly one timestamp.
- R4: When `any_edge` is 0, only changes toward the level given by `RISE_POL` produce a timestamp (default `RISE_POL`=1: 0 to 1 only). Changes in the other direction produce nothing on `ts_valid`.
- R5: With `ts_ready` held high, a change of `rd_line` on every clock cycle is recorded without loss. The timestamps leave in order of arrival.
- R6: While `ts_valid` is 1 and `ts_ready` is 0, `ts_valid` stays 1 and `ts_data` does not change on the next cycle.
- R7: While the stream is stalled, the block holds up to two timestamps. A further qualifying change is dropped and `ovf` goes to 1. Once `ts_ready` rises, the two held timestamps are delivered in order.
- R8: Once set, `ovf` stays 1 until reset. Later captures continue to work normally.
- R9: The time counter wraps from 2^TS_W-1 to 0. Timestamps taken after the wrap follow R2 modulo 2^TS_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_line | input | 1 | Raw asynchronous read-data line |
| any_edge | input | 1 | 1: record both directions; 0: record one direction only |
| ts_valid | output | 1 | Timestamp available |
| ts_ready | input | 1 | Consumer accepts the timestamp |
| ts_data | output | TS_W | Captured counter value |
| ovf | output | 1 | Sticky flag: a timestamp was dropped |

## Verification
The scoreboard compares each delivered timestamp with the edge index at which the bench changed the line. An off-by-one in the synchronizer depth, or a counter that starts late, shows up at the ports as a miscompare on the very first timestamp. A wrong detect polarity or a missing mode gate shows up as either a missing item or an unexpected item within four cycles of the change. A skid entry that is lost or reordered changes the contents or order of items once ready rises after a stall. An overflow flag that clears by itself is seen when `ovf` is sampled after the stalled items drain.

// File: rtl/flux_pkg.sv
package flux_pkg;
  typedef enum logic {
    MODE_ONE_DIR = 1'b0,
    MODE_ANY     = 1'b1
  } det_mode_e;
endpackage

// File: rtl/flux_rst_sync.sv
module flux_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/flux_detect.sv
module flux_detect
  import flux_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit RISE_POL    = 1'b1
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      line_i,
  input  det_mode_e mode_i,
  output logic      hit_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   cur_q, cur_d;
  logic                   prev_q, prev_d;
  logic                   any_chg;
  logic                   dir_chg;

  always_comb begin
    sync_d[0] = line_i;
    for (int i = 1; i < SYNC_STAGES; i++) sync_d[i] = sync_q[i-1];
    cur_d  = sync_q[SYNC_STAGES-1];
    prev_d = cur_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  assign any_chg = cur_q ^ prev_q;

  generate
    if (RISE_POL) begin : g_rise
      assign dir_chg = cur_q & ~prev_q;
    end else begin : g_fall
      assign dir_chg = ~cur_q & prev_q;
    end
  endgenerate

  assign hit_o = (mode_i == MODE_ANY) ? any_chg : dir_chg;

  // a directional hit is always also a level change
  AST_DIR_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i == MODE_ONE_DIR && hit_o) |-> (cur_q != prev_q)); // R4
endmodule

// File: rtl/flux_timer.sv
module flux_timer #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_ni,
  output logic [TS_W-1:0] cnt_o
);
  logic [TS_W-1:0] cnt_q, cnt_d;
  logic            run_q;

  always_comb cnt_d = cnt_q + TS_W'(1);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    run_q |-> (cnt_q == TS_W'($past(cnt_q) + TS_W'(1)))); // R9
endmodule

// File: rtl/flux_skid.sv
module flux_skid #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [TS_W-1:0] stamp_i,
  output logic            valid_o,
  input  logic            ready_i,
  output logic [TS_W-1:0] data_o,
  output logic            ovf_o
);
  logic [TS_W-1:0] out_q, out_d, skid_q, skid_d;
  logic            out_v_q, out_v_d, skid_v_q, skid_v_d;
  logic            ovf_q, ovf_d;
  logic            pop;

  assign pop = out_v_q & ready_i;

  always_comb begin
    out_d    = out_q;
    out_v_d  = out_v_q;
    skid_d   = skid_q;
    skid_v_d = skid_v_q;
    ovf_d    = ovf_q;
    if (pop) begin
      if (skid_v_q) begin
        out_d = skid_q;
        if (push_i) skid_d = stamp_i;
        else        skid_v_d = 1'b0;
      end else if (push_i) begin
        out_d = stamp_i;
      end else begin
        out_v_d = 1'b0;
      end
    end else if (push_i) begin
      if (!out_v_q) begin
        out_d   = stamp_i;
        out_v_d = 1'b1;
      end else if (!skid_v_q) begin
        skid_d   = stamp_i;
        skid_v_d = 1'b1;
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= '0;
      out_v_q  <= 1'b0;
      skid_q   <= '0;
      skid_v_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      out_q    <= out_d;
      out_v_q  <= out_v_d;
      skid_q   <= skid_d;
      skid_v_q <= skid_v_d;
      ovf_q    <= ovf_d;
    end
  end

  assign valid_o = out_v_q;
  assign data_o  = out_q;
  assign ovf_o   = ovf_q;

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R8
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ovf_o) |-> ($past(skid_v_q) && valid_o)); // R7
  AST_PUSH_SEEN: assert property (@(posedge clk) disable iff (!rst_ni)
    (push_i && !valid_o) |=> valid_o); // R3
endmodule

// File: rtl/flux_stamp.sv
module flux_stamp
  import flux_pkg::*;
#(
  parameter int TS_W        = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit RISE_POL    = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_line,
  input  logic            any_edge,
  output logic            ts_valid,
  input  logic            ts_ready,
  output logic [TS_W-1:0] ts_data,
  output logic            ovf
);
  logic            rst_q;
  logic            hit;
  logic [TS_W-1:0] now;
  det_mode_e       mode;

  assign mode = det_mode_e'(any_edge);

  flux_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_q)
  );

  flux_detect #(.SYNC_STAGES(SYNC_STAGES), .RISE_POL(RISE_POL)) u_det (
    .clk(clk), .rst_ni(rst_q), .line_i(rd_line), .mode_i(mode), .hit_o(hit)
  );

  flux_timer #(.TS_W(TS_W)) u_tmr (
    .clk(clk), .rst_ni(rst_q), .cnt_o(now)
  );

  flux_skid #(.TS_W(TS_W)) u_skid (
    .clk(clk), .rst_ni(rst_q), .push_i(hit), .stamp_i(now),
    .valid_o(ts_valid), .ready_i(ts_ready), .data_o(ts_data), .ovf_o(ovf)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_q |-> (!ts_valid && !ovf)); // R1
endmodule

// File: tb/flux_stamp_bench.sv
module flux_stamp_bench;
  localparam int TSW = 10;
  localparam int WD_CYCLES = 20000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           rd_line;
  logic           any_edge;
  logic           ts_valid;
  logic           ts_ready;
  logic [TSW-1:0] ts_data;
  logic           ovf;

  int n_checks = 0;
  int n_fail   = 0;
  int ecnt     = 0;
  bit done     = 1'b0;
  logic [TSW-1:0] expq[$];

  always #10 clk = ~clk;

  flux_stamp #(.TS_W(TSW)) u_flux_stamp (
    .clk(clk), .rst_n(rst_n), .rd_line(rd_line), .any_edge(any_edge),
    .ts_valid(ts_valid), .ts_ready(ts_ready), .ts_data(ts_data), .ovf(ovf)
  );

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // change the line at a falling edge; the next rising edge samples it
  task automatic drive(input logic lvl, input bit keep);
    @(negedge clk);
    rd_line = lvl;
    if (keep) expq.push_back(TSW'(ecnt + 1));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: a transfer takes place at the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && ts_valid && ts_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2/R4 unexpected item", int'(ts_data), -1);
        end else begin
          logic [TSW-1:0] e;
          e = expq.pop_front();
          check(ts_data == e, "R2 timestamp", int'(ts_data), int'(e));
        end
      end
    end
  end

  initial begin
    #(WD_CYCLES * 20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_line = 1'b0; any_edge = 1'b1; ts_ready = 1'b1;
    idle(3);
    check(!ts_valid && !ovf, "R1 in reset", int'(ts_valid) + int'(ovf), 0);
    rst_n = 1'b1;
    idle(6);
    check(!ts_valid && !ovf, "R1 after release", int'(ts_valid) + int'(ovf), 0);

    // R3: both directions in any-edge mode
    drive(1'b1, 1'b1); idle(6);
    drive(1'b0, 1'b1); idle(6);
    check(expq.size() == 0, "R3 both edges delivered", expq.size(), 0);

    // R5: a change every cycle
    for (int i = 0; i < 8; i++) drive(~rd_line, 1'b1);
    idle(8);
    check(expq.size() == 0, "R5 burst delivered", expq.size(), 0);
    check(!ovf, "R5 no overflow", int'(ovf), 0);

    // R4: single-direction mode, rising only
    any_edge = 1'b0;
    idle(2);
    drive(1'b1, 1'b1); idle(6);
    drive(1'b0, 1'b0); idle(6);
    check(!ts_valid, "R4 falling edge ignored", int'(ts_valid), 0);
    drive(1'b1, 1'b1); idle(6);
    check(expq.size() == 0, "R4 rising delivered", expq.size(), 0);
    drive(1'b0, 1'b0); idle(6);
    check(!ts_valid, "R4 falling edge ignored again", int'(ts_valid), 0);

    // R6/R7: stall, fill both entries, drop a third
    any_edge = 1'b1;
    ts_ready = 1'b0;
    idle(2);
    drive(1'b1, 1'b1); idle(2);
    drive(1'b0, 1'b1); idle(2);
    check(!ovf, "R7 two held without overflow", int'(ovf), 0);
    drive(1'b1, 1'b0); idle(6);
    check(ovf, "R7 overflow on third", int'(ovf), 1);
    check(ts_valid && ts_data == expq[0], "R6 held head", int'(ts_data), int'(expq[0]));
    idle(3);
    check(ts_valid && ts_data == expq[0], "R6 still held", int'(ts_data), int'(expq[0]));
    ts_ready = 1'b1;
    idle(6);
    check(expq.size() == 0, "R7 held items drained", expq.size(), 0);
    check(ovf, "R8 overflow sticky", int'(ovf), 1);

    // R8: capture still works after overflow
    drive(1'b0, 1'b1); idle(6);
    check(expq.size() == 0, "R8 capture after overflow", expq.size(), 0);
    check(ovf, "R8 still set", int'(ovf), 1);

    // R9: past the counter wrap
    idle(1100);
    drive(1'b1, 1'b1); idle(6);
    drive(1'b0, 1'b1); idle(6);
    check(expq.size() == 0, "R9 wrapped stamps delivered", expq.size(), 0);
    check(!ts_valid, "R9 stream idle", int'(ts_valid), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule